// File: doc/BRIEF.md
# Byte-Transfer Serial Host with Device Routing

This block is the register-level front end of a serial peripheral bus host. Software programs a 16-bit control word and then moves bytes through an 8-bit data port. Every accepted data write is handed to one attached byte-level target: a power-management target or a flash target. The control word picks the target. The chip-select hold state travels with the byte as a flag. The host also offers the target's current response byte for reading.

The control word carries several fields. Bit 15 is the master enable. Bit 14 enables the per-transfer interrupt. Bit 11 is the hold flag. Bit 10 requests a 16-bit transfer mode, which this block does not implement. Bits 9:8 form the target code. Bits 1:0 are kept only as stored data. The targets do not clock individual bits, and no rate timing is produced. Each target sees a one-cycle write strobe, a shared byte bus and the hold flag, and it returns its response byte on its own input lane.

Top module: `spi_host_ctrl`

## Requirements
- R1: A control write stores only the bits set in mask 0xCF03 (bits 15, 14, 11, 10, 9, 8, 1, 0). The stored word reads back on `ctl_rdata` from the cycle after the write, with every other bit 0.
- R2: After reset, `ctl_rdata` is 0x0000, `irq` is 0 and `mode_err` is 0.
- R3: While control bit 15 is 0, a data write raises no target strobe.
- R4: While control bit 15 is 0, `dat_rdata` is 0.
- R5: With bit 15 set, target code 00 (bits 9:8) routes a data write to target 0 (power management) and code 01 routes it to target 1 (flash). The byte appears on `dev_byte` in the same cycle as the single strobe `dev_we[code]`.
- R6: Target codes 10 and 11 raise no strobe, and `dat_rdata` reads 0 while either code is selected.
- R7: `dev_hold` equals stored control bit 11 and accompanies every forwarded byte.
- R8: A data write accepted while bits 15 and 14 are both set produces `irq` high for exactly the following cycle.
- R9: A data write made while bit 15 is clear produces no `irq`, even when bit 14 is set.
- R10: A control write with bit 10 set raises `mode_err`. The flag stays high until reset.
- R11: `dat_rdata` combinationally follows the response lane of the selected target while the host is enabled.
- R12: A data write in the same cycle as a control write is routed and gated by the control word stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Stored control word |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Byte to forward |
| dat_rdata | output | 8 | Response byte of the selected target |
| irq | output | 1 | One-cycle transfer interrupt |
| mode_err | output | 1 | Sticky unsupported-mode flag |
| dev_we | output | NUM_DEV | Per-target byte strobe |
| dev_byte | output | 8 | Byte bus shared by the targets |
| dev_hold | output | 1 | Chip-select hold flag |
| dev_resp | input | NUM_DEV*8 | Response lanes, target i at bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: two targets and an 8-bit byte. With two targets, half of the four target codes are unmapped, so the discard path for codes 10 and 11 is covered alongside both live routes. The target response lanes change to fresh values on every cycle, so a stale or mis-routed read shows up at once. The sequences also cover same-cycle control and data writes, and disabled writes with the interrupt enabled.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int CTL_W    = 16;
  localparam int EN_BIT   = 15;
  localparam int IE_BIT   = 14;
  localparam int HOLD_BIT = 11;
  localparam int WIDE_BIT = 10;
  localparam int SEL_LO   = 8;
  localparam int SEL_W    = 2;
  localparam logic [CTL_W-1:0] CTL_MASK = 16'hCF03;
endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic             wide_err
);
  logic [CTL_W-1:0] ctl_d;
  logic             err_d;
  logic             ctl_en;

  assign ctl_en = ctl_we;

  always_comb begin
    ctl_d = ctl_wdata & CTL_MASK;
    err_d = wide_err | (ctl_we & ctl_wdata[WIDE_BIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      wide_err <= 1'b0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      wide_err <= err_d;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wide_err |=> wide_err); // R10
endmodule

// File: rtl/spi_dev_router.sv
module spi_dev_router #(
  parameter int NUM_DEV = 2,
  parameter int DW      = 8,
  parameter int SEL_W   = 2
) (
  input  logic                  en,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  dat_we,
  input  logic [NUM_DEV*DW-1:0] dev_resp,
  output logic [NUM_DEV-1:0]    dev_we,
  output logic [DW-1:0]         dat_rdata
);
  logic [NUM_DEV-1:0] hit;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign hit[i]    = en && (sel == SEL_W'(i));
    assign dev_we[i] = hit[i] && dat_we;
  end

  always_comb begin
    dat_rdata = '0;
    for (int k = 0; k < NUM_DEV; k++) begin
      if (hit[k]) dat_rdata = dev_resp[k*DW +: DW];
    end
  end
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic irq
);
  logic irq_d;

  always_comb irq_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DW      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic [15:0]           ctl_wdata,
  output logic [15:0]           ctl_rdata,
  input  logic                  dat_we,
  input  logic [DW-1:0]         dat_wdata,
  output logic [DW-1:0]         dat_rdata,
  output logic                  irq,
  output logic                  mode_err,
  output logic [NUM_DEV-1:0]    dev_we,
  output logic [DW-1:0]         dev_byte,
  output logic                  dev_hold,
  input  logic [NUM_DEV*DW-1:0] dev_resp
);
  logic [CTL_W-1:0] ctl_q;
  logic             en;
  logic             fire;

  spi_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .wide_err(mode_err)
  );

  assign en = ctl_q[EN_BIT];

  spi_dev_router #(.NUM_DEV(NUM_DEV), .DW(DW), .SEL_W(SEL_W)) u_route (
    .en(en), .sel(ctl_q[SEL_LO +: SEL_W]), .dat_we(dat_we),
    .dev_resp(dev_resp), .dev_we(dev_we), .dat_rdata(dat_rdata)
  );

  assign fire = dat_we && en && ctl_q[IE_BIT];

  spi_irq_gen u_irq (.clk(clk), .rst_n(rst_n), .fire(fire), .irq(irq));

  assign ctl_rdata = ctl_q;
  assign dev_byte  = dat_wdata;
  assign dev_hold  = ctl_q[HOLD_BIT];

  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == ($past(ctl_wdata) & CTL_MASK)); // R1
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[EN_BIT] |-> (dev_we == '0 && dat_rdata == '0)); // R3
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_we)); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(dat_we && ctl_rdata[EN_BIT] && ctl_rdata[IE_BIT])); // R8
endmodule

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic [7:0]  dat_rdata;
  logic        irq, mode_err;
  logic [1:0]  dev_we;
  logic [7:0]  dev_byte;
  logic        dev_hold;
  logic [15:0] dev_resp = '0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_ctl = 0;
  int m_irq = 0;
  int m_err = 0;

  always #4 clk = ~clk;

  spi_host_ctrl u_spi_host_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .irq(irq), .mode_err(mode_err), .dev_we(dev_we),
    .dev_byte(dev_byte), .dev_hold(dev_hold), .dev_resp(dev_resp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit cw, input int cwd, input bit dw, input int dwd);
    int en, sel, exp_we, exp_rd;
    @(negedge clk);
    ctl_we = cw; ctl_wdata = cwd[15:0]; dat_we = dw; dat_wdata = dwd[7:0];
    dev_resp = $urandom();
    #1;
    chk("R1 ctl_rdata", int'(ctl_rdata), m_ctl);
    chk("R8 R9 irq", int'(irq), m_irq);
    chk("R10 mode_err", int'(mode_err), m_err);
    en  = (m_ctl >> 15) & 1;
    sel = (m_ctl >> 8) & 3;
    exp_we = (dw && en && sel < 2) ? (1 << sel) : 0;
    exp_rd = (en && sel < 2) ? int'(dev_resp[sel*8 +: 8]) : 0;
    chk("R3 R5 R6 R12 dev_we", int'(dev_we), exp_we);
    chk("R4 R6 R11 dat_rdata", int'(dat_rdata), exp_rd);
    chk("R7 dev_hold", int'(dev_hold), (m_ctl >> 11) & 1);
    if (exp_we != 0) chk("R5 dev_byte", int'(dev_byte), dwd & 8'hFF);
    @(posedge clk);
    m_irq = (dw && en && ((m_ctl >> 14) & 1)) ? 1 : 0;
    if (cw) begin
      m_ctl = cwd & 16'hCF03;
      if ((cwd >> 10) & 1) m_err = 1;
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0);                      // R2 reset state
    step(1, 16'h30FC, 1, 8'h11);           // R1 all unmasked bits dropped, R3 off
    step(1, 16'h4000, 1, 8'h22);           // R9 ie only, disabled write
    step(0, 0, 1, 8'h33);                  // R9 no irq
    step(1, 16'h8000, 0, 0);               // enable, target 0
    step(0, 0, 1, 8'hA5);                  // R5 to power management
    step(1, 16'hC900, 0, 0);               // R7 hold, ie, target 1
    step(0, 0, 1, 8'h3C);                  // R5 flash, R8 irq next
    step(0, 0, 1, 8'h3D);                  // R8 back to back
    step(0, 0, 0, 0);                      // R8 pulse ends
    step(1, 16'hC200, 1, 8'h44);           // R12 old code 01 still routes
    step(0, 0, 1, 8'h55);                  // R6 code 10 discarded
    step(1, 16'hC303, 1, 8'h66);           // R12 code 10 still in force
    step(0, 0, 1, 8'h77);                  // R6 code 11 discarded
    step(1, 16'h0100, 1, 8'h88);           // R12 enable holds this cycle
    step(0, 0, 1, 8'h99);                  // R3 R4 disabled
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0);  // R11 lane follows
    step(1, 16'h8100, 0, 0);
    for (int i = 0; i < 20; i++) step(i % 3 == 0, (i % 2) ? 16'h8100 : 16'hC800, 1, i); // R11 R5
    step(1, 16'hFFFF, 0, 0);               // R1 mask, R10 set
    step(1, 16'h0000, 0, 0);               // R10 sticky
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule